// File: doc/BRIEF.md
# Three-Tap FIR Filter with Cutset Pipelining

The block filters a stream of signed samples with three programmable taps. It produces one full-precision result for each accepted sample. Each result is the weighted sum of the current sample and the two samples accepted before it. Samples arrive with a valid strobe. Cycles without the strobe are bubbles: they leave the sample history untouched and pass to the output as cycles without the output strobe, in order.

A register bank sits on a feed-forward cutset. One side of the cut holds the sum of the two leading products, and the other side holds the trailing product. The longest register-to-register path is therefore one multiplier followed by one adder, and two samples are in flight at once. A parameter adds fine-grain pipelining: each multiplier is split into two stages, with partial products registered between them.

The coefficients are plain inputs. The filter expects them to change only while no sample is in flight.

Top module: `fir3_cutset`

## Requirements
- R1: For every accepted sample x(n), the output that appears with the output strobe equals A·x(n) + B·x(n−1) + C·x(n−2), where x(n−1) and x(n−2) are the two previously accepted samples and A, B and C are the tap_a, tap_b and tap_c inputs.
- R2: With FINE = 0, `y_vld` equals `smp_vld` from exactly two clock cycles earlier, and the matching result is on `y_out` in that same cycle.
- R3: With FINE = 1, the multipliers are split into two registered stages and `y_vld` equals `smp_vld` from exactly three cycles earlier. In this mode, each multiplier output equals the exact product of its operands from the previous cycle.
- R4: A cycle with `smp_vld` low does not advance the sample history. The next accepted sample still combines with the last two accepted samples, however many bubbles lie between them.
- R5: A synchronous, active-high `rst` clears the history and all pipeline registers. In the cycles after reset, `y_out` is 0 and `y_vld` is 0. The first results after reset use zero for past samples that are missing.
- R6: `y_out` is a 34-bit two's-complement value with no rounding or wrap. The extreme case of three products of −32768·−32768 is represented exactly.
- R7: New coefficient values applied while no sample is in flight are used, in full, by the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 16 | Signed input sample |
| smp_vld | input | 1 | Marks smp_in as an accepted sample |
| tap_a | input | 16 | Signed coefficient for the current sample |
| tap_b | input | 16 | Signed coefficient for the previous sample |
| tap_c | input | 16 | Signed coefficient for the sample before that |
| y_out | output | 34 | Signed filter result |
| y_vld | output | 1 | Marks y_out as a result |

## Verification
With back-to-back samples, the tap line shifts in the same cycle that the previous sample's partial sum crosses the cutset register, so two iterations share a clock. Runs of consecutive strobes provoke this overlap. Random bubble patterns break the overlap in a second phase. In both modes, a behavioural model built on queues checks every cycle's strobe and value, so a result mixed with the neighbouring iteration is caught. Extreme operands and a reset issued in the middle of the run cover range and restart.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;

  // exact width of one sample-by-coefficient product
  function automatic int prod_w(input int dw, input int cw);
    return dw + cw;
  endfunction

  // three products summed need two growth bits
  function automatic int out_w(input int dw, input int cw);
    return dw + cw + 2;
  endfunction

  // cutset stage + output stage, plus one when multipliers are split
  function automatic int latency(input bit fine);
    return fine ? 3 : 2;
  endfunction
endpackage

// File: rtl/fir3_tapline.sv
module fir3_tapline #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] x1,
  output logic signed [DW-1:0] x2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x1 <= '0;
      x2 <= '0;
    end else if (shift) begin
      x1 <= din;
      x2 <= x1;
    end
  end

  // R4
  tap_shift_chk: assert property (@(posedge clk) disable iff (rst)
    shift |=> (x1 == $past(din) && x2 == $past(x1)));

  // R4
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift |=> ($stable(x1) && $stable(x2)));
endmodule

// File: rtl/fir3_mult_fine.sv
module fir3_mult_fine #(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] k,
  output logic signed [PW-1:0] p
);
  localparam int LW  = CW / 2;
  localparam int HW  = CW - LW;
  localparam int LOW = DW + LW + 1;
  localparam int HIW = DW + HW;

  // sample times the unsigned low slice of the coefficient
  function automatic logic signed [LOW-1:0] part_lo(input logic signed [DW-1:0] a,
                                                    input logic signed [CW-1:0] b);
    return LOW'(a) * LOW'($signed({1'b0, b[LW-1:0]}));
  endfunction

  // sample times the signed high slice of the coefficient
  function automatic logic signed [HIW-1:0] part_hi(input logic signed [DW-1:0] a,
                                                    input logic signed [CW-1:0] b);
    return HIW'(a) * HIW'($signed(b[CW-1:LW]));
  endfunction

  function automatic logic signed [PW-1:0] join_parts(input logic signed [LOW-1:0] lo,
                                                      input logic signed [HIW-1:0] hi);
    return (PW'(hi) <<< LW) + PW'(lo);
  endfunction

  function automatic logic signed [PW-1:0] whole_prod(input logic signed [DW-1:0] a,
                                                      input logic signed [CW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  logic signed [LOW-1:0] lo_q;
  logic signed [HIW-1:0] hi_q;
  logic                  armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      armed <= 1'b0;
    end else begin
      lo_q  <= part_lo(x, k);
      hi_q  <= part_hi(x, k);
      armed <= 1'b1;
    end
  end

  assign p = join_parts(lo_q, hi_q);

  // R3
  split_prod_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (p == whole_prod($past(x), $past(k))));
endmodule

// File: rtl/fir3_cutset.sv
module fir3_cutset
  import fir3_pkg::*;
#(
  parameter int DW   = SAMPLE_W,
  parameter int CW   = COEF_W,
  parameter bit FINE = 1'b0,
  localparam int OW  = out_w(DW, CW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] smp_in,
  input  logic                 smp_vld,
  input  logic signed [CW-1:0] tap_a,
  input  logic signed [CW-1:0] tap_b,
  input  logic signed [CW-1:0] tap_c,
  output logic signed [OW-1:0] y_out,
  output logic                 y_vld
);
  localparam int PW  = prod_w(DW, CW);
  localparam int LAT = latency(FINE);
  localparam int NT  = 3;

  function automatic logic signed [PW-1:0] full_prod(input logic signed [DW-1:0] a,
                                                     input logic signed [CW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  function automatic logic signed [PW:0] lead_sum(input logic signed [PW-1:0] p0,
                                                  input logic signed [PW-1:0] p1);
    return (PW+1)'(p0) + (PW+1)'(p1);
  endfunction

  function automatic logic signed [OW-1:0] final_sum(input logic signed [PW:0] s,
                                                     input logic signed [PW-1:0] t);
    return OW'(s) + OW'(t);
  endfunction

  logic signed [DW-1:0] hist1, hist2;

  fir3_tapline #(.DW(DW)) u_taps (
    .clk  (clk),
    .rst  (rst),
    .shift(smp_vld),
    .din  (smp_in),
    .x1   (hist1),
    .x2   (hist2)
  );

  logic signed [DW-1:0] opx  [NT];
  logic signed [CW-1:0] opk  [NT];
  logic signed [PW-1:0] prod [NT];
  logic                 prod_vld;

  assign opx[0] = smp_in;
  assign opx[1] = hist1;
  assign opx[2] = hist2;
  assign opk[0] = tap_a;
  assign opk[1] = tap_b;
  assign opk[2] = tap_c;

  generate
    if (FINE) begin : g_fine
      for (genvar i = 0; i < NT; i++) begin : g_tap
        fir3_mult_fine #(.DW(DW), .CW(CW)) u_mul (
          .clk(clk),
          .rst(rst),
          .x  (opx[i]),
          .k  (opk[i]),
          .p  (prod[i])
        );
      end
      logic vld_m;
      always_ff @(posedge clk) begin
        if (rst) vld_m <= 1'b0;
        else     vld_m <= smp_vld;
      end
      assign prod_vld = vld_m;
    end else begin : g_flat
      for (genvar i = 0; i < NT; i++) begin : g_tap
        assign prod[i] = full_prod(opx[i], opk[i]);
      end
      assign prod_vld = smp_vld;
    end
  endgenerate

  // feed-forward cutset: lead pair summed, trailing product carried alone
  logic signed [PW:0]   ab_q;
  logic signed [PW-1:0] c_q;
  logic                 cut_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_q     <= '0;
      c_q      <= '0;
      cut_fire <= 1'b0;
    end else begin
      ab_q     <= lead_sum(prod[0], prod[1]);
      c_q      <= prod[2];
      cut_fire <= prod_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out <= '0;
      y_vld <= 1'b0;
    end else begin
      y_out <= final_sum(ab_q, c_q);
      y_vld <= cut_fire;
    end
  end

  // cycles since reset, saturating, for the latency check window
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2 R3
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(since_rst) >= LAT) |-> (y_vld == $past(smp_vld, LAT)));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (y_out == '0 && !y_vld));
endmodule

// File: tb/sim_fir3_cutset.sv
module sim_fir3_cutset;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int OW = 34;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst = 1'b1;
  logic                 smp_vld = 1'b0;
  logic signed [DW-1:0] smp_in = '0;
  logic signed [CW-1:0] ca = '0, cb = '0, cc = '0;
  wire  signed [OW-1:0] y0, y1;
  wire                  v0, v1;

  fir3_cutset #(.DW(DW), .CW(CW), .FINE(1'b0)) u0 (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
    .tap_a(ca), .tap_b(cb), .tap_c(cc), .y_out(y0), .y_vld(v0));

  fir3_cutset #(.DW(DW), .CW(CW), .FINE(1'b1)) u1 (
    .clk(clk), .rst(rst), .smp_in(smp_in), .smp_vld(smp_vld),
    .tap_a(ca), .tap_b(cb), .tap_c(cc), .y_out(y1), .y_vld(v1));

  int total = 0, bad = 0, wd = 0;
  bit done = 1'b0;
  string tag = "R1";
  longint ka = 0, kb = 0, kc = 0, h1 = 0, h2 = 0;
  bit     qv0[$], qv1[$];
  longint qy0[$], qy1[$];

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", wd);
      finish_up();
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd16();
    logic signed [15:0] r;
    r = 16'($urandom);
    return int'(r);
  endfunction

  // one clock: check outputs due now, then drive the next input
  task automatic cycle(bit v, int x);
    bit     ev;
    longint ey;
    @(negedge clk);
    ev = qv0.pop_front(); ey = qy0.pop_front();
    chk("R2", "u0 valid", longint'(v0), longint'(ev));
    if (ev && v0) chk(tag, "u0 value", longint'(y0), ey);
    ev = qv1.pop_front(); ey = qy1.pop_front();
    chk("R3", "u1 valid", longint'(v1), longint'(ev));
    if (ev && v1) chk(tag, "u1 value", longint'(y1), ey);
    smp_vld = v;
    smp_in  = DW'(x);
    if (v) begin
      ey = ka * longint'(x) + kb * h1 + kc * h2;
      h2 = h1;
      h1 = longint'(x);
    end else ey = 0;
    qv0.push_back(v); qy0.push_back(ey);
    qv1.push_back(v); qy1.push_back(ey);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 0);
  endtask

  task automatic set_taps(int a, int b, int c);
    idle(4);
    ka = longint'(a); kb = longint'(b); kc = longint'(c);
    ca = CW'(a); cb = CW'(b); cc = CW'(c);
  endtask

  // R5: hold reset, check cleared outputs, release and realign model
  task automatic reset_seq();
    rst = 1'b1;
    smp_vld = 1'b0;
    smp_in = '0;
    repeat (3) @(negedge clk);
    chk("R5", "u0 out after reset", longint'(y0), 0);
    chk("R5", "u0 valid after reset", longint'(v0), 0);
    chk("R5", "u1 out after reset", longint'(y1), 0);
    chk("R5", "u1 valid after reset", longint'(v1), 0);
    rst = 1'b0;
    h1 = 0; h2 = 0;
    qv0.delete(); qy0.delete(); qv1.delete(); qy1.delete();
    for (int i = 0; i < 2; i++) begin qv0.push_back(1'b0); qy0.push_back(0); end
    for (int i = 0; i < 3; i++) begin qv1.push_back(1'b0); qy1.push_back(0); end
  endtask

  initial begin
    reset_seq();

    // R1: back-to-back samples, first ones see zero history (R5)
    tag = "R1";
    set_taps(3, -5, 7);
    for (int i = 0; i < 24; i++) cycle(1'b1, rnd16());

    // R4: random bubbles between accepted samples
    tag = "R4";
    for (int i = 0; i < 60; i++) cycle(1'($urandom % 2), rnd16());
    cycle(1'b1, 1000);
    idle(5);
    cycle(1'b1, -2000);
    idle(3);
    cycle(1'b1, 300);

    // R7: coefficients changed while idle take effect next sample
    tag = "R7";
    set_taps(rnd16(), rnd16(), rnd16());
    for (int i = 0; i < 30; i++) cycle(1'($urandom % 4 != 0), rnd16());
    set_taps(-1, 2, -32768);
    for (int i = 0; i < 10; i++) cycle(1'b1, rnd16());

    // R6: extreme operands need the full 34-bit range
    tag = "R6";
    set_taps(-32768, -32768, -32768);
    for (int i = 0; i < 5; i++) cycle(1'b1, -32768);
    set_taps(32767, -32768, 32767);
    for (int i = 0; i < 5; i++) cycle(1'b1, (i % 2 == 0) ? -32768 : 32767);

    // R5: reset mid-run, history restarts from zero
    idle(4);
    reset_seq();
    tag = "R5";
    for (int i = 0; i < 6; i++) cycle(1'b1, rnd16());

    // R1: random coefficient rounds with mixed traffic
    tag = "R1";
    for (int r = 0; r < 10; r++) begin
      set_taps(rnd16(), rnd16(), rnd16());
      for (int i = 0; i < 30; i++) cycle(1'($urandom % 3 != 0), rnd16());
    end
    idle(6);
    finish_up();
  end
endmodule